// File: doc/BRIEF.md
# Reshapeable Two-Clock Simple Dual-Port RAM

This block holds 1,152 bits of storage behind one write port and one read port. Each port runs on its own clock. A 2-bit shape input presents the same array as 64 words of 18 bits, 128 words of 9 bits, 256 words of 4 bits or 512 words of 2 bits. The address buses are 9 bits wide and the data buses are 18 bits wide, which covers the deepest and the widest shape.

A narrow word is a slice of one 18-bit physical row. The low six address bits pick the row. The address bits above them that the shape needs pick the slice within that row. A per-port control chooses how the read side works. In one setting, read data comes from a register that loads on the read clock when the read enable is high. In the other, read data follows the read address combinationally. The shape is meant to stay fixed while the memory is in use.

Top module: `cfg_dpram`

## Requirements
- R1: While rst_ni is low, the read-data register is cleared, and with async_rd_i low rdata_o reads 0. The array contents are not reset.
- R2: mode_i=00 gives a 64x18 shape. waddr_i/raddr_i[5:0] select the word, address bits [8:6] are ignored, and all 18 data bits are used.
- R3: mode_i=01 gives a 128x9 shape. Address bits [6:0] are used and bits [8:7] are ignored. Bit 6 picks row bits [8:0] (0) or [17:9] (1). Data sits in bits [8:0].
- R4: mode_i=10 gives a 256x4 shape. Address bits [7:0] are used and bit 8 is ignored. Bits [7:6]=k pick row bits [4k+3:4k]. Data sits in bits [3:0].
- R5: mode_i=11 gives a 512x2 shape. All nine address bits are used. Bits [8:6]=k pick row bits [2k+1:2k]. Data sits in bits [1:0].
- R6: A write happens only on a rising wclk_i edge with we_i high. With we_i low, the array does not change.
- R7: With async_rd_i low and re_i high at a rising rclk_i edge, rdata_o shows the word at raddr_i after that edge.
- R8: With async_rd_i low and re_i low at a rising rclk_i edge, rdata_o keeps its previous value.
- R9: With async_rd_i high, rdata_o follows raddr_i combinationally, with no rclk_i edge needed.
- R10: After a write to the address being read, the new word appears on rdata_o. With async_rd_i high it appears straight after the wclk_i edge. With async_rd_i low it appears after the next enabled rclk_i edge.
- R11: A narrow write changes only its own slice of the physical row. Write-data bits above the word width are ignored.
- R12: Read-data bits above the word width of the current shape read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the read-data register |
| mode_i | input | 2 | Shape: 00 64x18, 01 128x9, 10 256x4, 11 512x2 |
| async_rd_i | input | 1 | 1: combinational read; 0: registered read |
| we_i | input | 1 | Write enable, sampled on wclk_i |
| waddr_i | input | 9 | Write address |
| wdata_i | input | 18 | Write data, LSB-aligned |
| re_i | input | 1 | Read enable for the registered read, sampled on rclk_i |
| raddr_i | input | 9 | Read address |
| rdata_o | output | 18 | Read data, LSB-aligned, upper bits zero |

## Verification
Some properties are checked on every cycle:
- Each write touches exactly as many bits as the current shape's word width.
- Combinational reads drive no bits above that width.
- The registered read output holds when the enable is low.
- With the enable high, the registered output loads the decoded word.
- The output is zero during reset.

Other behaviour can only be shown by the bench's scenarios, which sweep every address of every shape:
- The slice mapping within each row.
- The fact that ignored address and data bits have no effect.
- Neighbouring slices stay intact after narrow writes.
- New data reaches the reader after a write to the address being read.

// File: rtl/cfg_dpram_pkg.sv
package cfg_dpram_pkg;
  typedef enum logic [1:0] {
    SHAPE_64X18  = 2'b00,
    SHAPE_128X9  = 2'b01,
    SHAPE_256X4  = 2'b10,
    SHAPE_512X2  = 2'b11
  } shape_e;
endpackage

// File: rtl/cfg_dpram_lane.sv
// Splits an address into physical row, slice offset and word mask for a shape.
module cfg_dpram_lane
  import cfg_dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ROW_AW = 6,
  localparam int unsigned ADDR_W = ROW_AW + 3,
  localparam int unsigned OFF_W  = $clog2(DATA_W)
) (
  input  shape_e              shape_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [ROW_AW-1:0]   row_o,
  output logic [OFF_W-1:0]    off_o,
  output logic [DATA_W-1:0]   low_o
);
  int unsigned lane_w;
  logic [2:0]  sel;

  always_comb begin
    lane_w = DATA_W >> shape_i;
    sel    = addr_i[ADDR_W-1:ROW_AW] & 3'((4'd1 << shape_i) - 4'd1);
    off_o  = OFF_W'(32'(sel) * lane_w);
    low_o  = DATA_W'((32'd1 << lane_w) - 32'd1);
  end

  assign row_o = addr_i[ROW_AW-1:0];
endmodule

// File: rtl/cfg_dpram_array.sv
// Physical row storage with a bit-masked write and a combinational row read.
module cfg_dpram_array #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ROW_AW = 6,
  localparam int unsigned ROWS  = 1 << ROW_AW
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ROW_AW-1:0] wrow_i,
  input  logic [DATA_W-1:0] wmask_i,
  input  logic [DATA_W-1:0] wbits_i,
  input  logic [ROW_AW-1:0] rrow_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] row_view [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [DATA_W-1:0] q;
    always_ff @(posedge wclk_i) begin
      if (we_i && (wrow_i == ROW_AW'(r))) q <= (q & ~wmask_i) | wbits_i;
    end
    assign row_view[r] = q;
  end

  assign rdata_o = row_view[rrow_i];
endmodule

// File: rtl/cfg_dpram.sv
module cfg_dpram
  import cfg_dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ROW_AW = 6,
  localparam int unsigned ADDR_W = ROW_AW + 3,
  localparam int unsigned OFF_W  = $clog2(DATA_W)
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              async_rd_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  shape_e            shape;
  logic [ROW_AW-1:0] w_row, r_row;
  logic [OFF_W-1:0]  w_off, r_off;
  logic [DATA_W-1:0] w_low, r_low;
  logic [DATA_W-1:0] wr_mask, wr_bits;
  logic [DATA_W-1:0] r_row_data, r_word, rd_q;

  assign shape = shape_e'(mode_i);

  cfg_dpram_lane #(.DATA_W(DATA_W), .ROW_AW(ROW_AW)) u_wlane (
    .shape_i(shape), .addr_i(waddr_i), .row_o(w_row), .off_o(w_off), .low_o(w_low)
  );

  cfg_dpram_lane #(.DATA_W(DATA_W), .ROW_AW(ROW_AW)) u_rlane (
    .shape_i(shape), .addr_i(raddr_i), .row_o(r_row), .off_o(r_off), .low_o(r_low)
  );

  assign wr_mask = w_low << w_off;
  assign wr_bits = (wdata_i & w_low) << w_off;

  cfg_dpram_array #(.DATA_W(DATA_W), .ROW_AW(ROW_AW)) u_array (
    .wclk_i (wclk_i),
    .we_i   (we_i),
    .wrow_i (w_row),
    .wmask_i(wr_mask),
    .wbits_i(wr_bits),
    .rrow_i (r_row),
    .rdata_o(r_row_data)
  );

  assign r_word = (r_row_data >> r_off) & r_low;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= r_word;
  end

  assign rdata_o = async_rd_i ? r_word : rd_q;
endmodule

// File: rtl/cfg_dpram_chk.sv
module cfg_dpram_chk #(
  parameter int unsigned DATA_W = 18
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              async_rd_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] wr_mask,
  input logic [DATA_W-1:0] r_word
);
  assert_mask_width_R11: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    we_i |-> ($countones(wr_mask) == (DATA_W >> mode_i)));

  assert_upper_zero_R12: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    async_rd_i |-> ((rdata_o >> (DATA_W >> mode_i)) == '0));

  assert_hold_R8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!re_i && !async_rd_i) |=> (async_rd_i || $stable(rdata_o)));

  assert_sync_load_R7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (re_i && !async_rd_i) |=> (async_rd_i || (rdata_o == $past(r_word))));

  always @(posedge rclk_i) begin
    if (!rst_ni && !async_rd_i)
      assert_reset_clear_R1: assert (rdata_o == '0) else $error("read register not cleared");
  end
endmodule

bind cfg_dpram cfg_dpram_chk #(.DATA_W(DATA_W)) u_chk (
  .wclk_i    (wclk_i),
  .rclk_i    (rclk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .async_rd_i(async_rd_i),
  .we_i      (we_i),
  .re_i      (re_i),
  .rdata_o   (rdata_o),
  .wr_mask   (wr_mask),
  .r_word    (r_word)
);

// File: tb/tb_cfg_dpram.sv
module tb_cfg_dpram;
  localparam int CLK_PERIOD = 10;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       async_rd = 1'b0, we = 1'b0, re = 1'b0;
  logic [8:0] waddr = '0, raddr = '0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  cfg_dpram dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .mode_i(mode),
    .async_rd_i(async_rd), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .re_i(re), .raddr_i(raddr), .rdata_o(rdata)
  );

  initial forever #(CLK_PERIOD/2) wclk = ~wclk;
  initial begin
    #3;
    forever #(CLK_PERIOD/2) rclk = ~rclk;
  end

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic string rq(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [17:0] pat(input int m, input int a);
    return 18'(((a * 2731) + (m * 977) + 13) ^ (a << 9));
  endfunction

  function automatic logic [17:0] low_of(input int m);
    return 18'((32'd1 << (18 >> m)) - 1);
  endfunction

  task automatic wr(input logic [8:0] a, input logic [17:0] d, input bit en);
    @(negedge wclk);
    we = en; waddr = a; wdata = d;
    @(negedge wclk);
    we = 1'b0;
  endtask

  task automatic sync_rd(input logic [8:0] a, output logic [17:0] d);
    async_rd = 1'b0;
    @(negedge rclk);
    re = 1'b1; raddr = a;
    @(negedge rclk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic async_rd_task(input logic [8:0] a, output logic [17:0] d);
    async_rd = 1'b1; raddr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] d;
    // R1: reset clears the registered output
    #2;
    chk("R1 in reset", rdata, 18'h0);
    #20;
    @(negedge rclk);
    rst_n = 1'b1;
    @(negedge rclk);
    chk("R1 after reset", rdata, 18'h0);

    for (int m = 0; m < 4; m++) begin
      int depth = 64 << m;
      mode = 2'(m);
      // writes with junk in ignored address bits and upper data bits (R11)
      for (int a = 0; a < depth; a++)
        wr(9'(a | (((a * 5) + 3) << (6 + m))), pat(m, a), 1'b1);
      // registered read, different junk in ignored address bits (R7, R11, R12)
      for (int a = 0; a < depth; a++) begin
        sync_rd(9'(a | (((a * 3) + 1) << (6 + m))), d);
        chk($sformatf("%s R7 sync a=%0d", rq(m), a), d, pat(m, a) & low_of(m));
      end
      // combinational read sweep (R9, R12)
      for (int a = 0; a < depth; a++) begin
        async_rd_task(9'(a), d);
        chk($sformatf("%s R9 async a=%0d", rq(m), a), d, pat(m, a) & low_of(m));
      end
      async_rd = 1'b0;
    end

    // R6: we low leaves the word untouched
    mode = 2'b01;
    wr(9'd5, 18'h0_0AB, 1'b1);
    wr(9'd5, 18'h0_155, 1'b0);
    sync_rd(9'd5, d);
    chk("R6 write disabled", d, 18'h0_0AB);

    // R8: re low holds the output while raddr moves
    wr(9'd70, 18'h0_033, 1'b1);
    sync_rd(9'd5, d);
    @(negedge rclk);
    raddr = 9'd70;
    @(negedge rclk);
    @(negedge rclk);
    chk("R8 hold", rdata, 18'h0_0AB);

    // R10: combinational read sees a write to the address being read
    async_rd = 1'b1; raddr = 9'd70;
    #1;
    chk("R10 async before", rdata, 18'h0_033);
    wr(9'd70, 18'h0_1C7, 1'b1);
    #1;
    chk("R10 async after write", rdata, 18'h0_1C7);

    // R10: registered read picks it up on the next enabled edge
    sync_rd(9'd70, d);
    wr(9'd70, 18'h0_0F0, 1'b1);
    chk("R10 sync still old", rdata, 18'h0_1C7);
    sync_rd(9'd70, d);
    chk("R10 sync new", d, 18'h0_0F0);

    // R11: other slice of the same row survives (row 6, slice 1 = addr 70; slice 0 = addr 6)
    wr(9'd6, 18'h3_FE5A, 1'b1);
    sync_rd(9'd70, d);
    chk("R11 neighbour slice", d, 18'h0_0F0);
    sync_rd(9'd6, d);
    chk("R11 upper data ignored", d, 18'h0_05A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule